// File: doc/BRIEF.md
# CPU Bus Cycle Sequencer and Address Generator

This block is the memory-access front end of an 8-bit processor. The execution unit hands it one request at a time, such as an opcode fetch, a stack push or pop, a direct-page read or write, an absolute read or write, or an internal (idle) cycle. Along with the request it supplies the current program counter, stack pointer and direct-page select flag. The block works out the bus address and the next PC and SP. It then runs one bus cycle of fixed length on the master clock.

Every bus cycle lasts `CYC_LEN` master clocks (24 by default). A read strobes the bus in the middle of the cycle (clock 12 by default), captures the returned byte, and presents it one clock later. A write strobes the bus in the last clock of the cycle. Every cycle, including an idle one, ends with a one-clock timer tick and a done pulse. While `busy` is high, new requests are ignored, so the execution unit has to wait for `done` before it issues the next one.

Top module: `cpu_bus_sequencer`

## Requirements
- R1: After synchronous reset, `busy`, `bus_rd`, `bus_wr`, `rdata_valid`, `tick` and `done` are 0, and `pc_out` and `sp_out` are 0.
- R2: A request is accepted on a clock edge where `req_valid`=1 and `busy`=0. `busy` is then 1 for exactly `CYC_LEN` clocks. A request presented while `busy`=1 is ignored and does not alter the cycle in flight or its address. Operation codes are: 0 idle, 1 fetch, 2 push, 3 pop, 4 direct-page read, 5 direct-page write, 6 absolute read, 7 absolute write.
- R3: An idle cycle (code 0) asserts neither `bus_rd` nor `bus_wr`.
- R4: A read cycle (codes 1, 3, 4, 6) asserts `bus_rd` only in clock `SAMPLE_AT` of the cycle, counting the first busy clock as 1. `bus_rdata` is captured at the end of that clock. In the next clock, `rdata_valid`=1 and `rdata_out` holds the captured byte.
- R5: A write cycle (codes 2, 5, 7) asserts `bus_wr` only in the last (`CYC_LEN`-th) busy clock, with `bus_wdata` equal to the `req_wdata` given at acceptance. It never asserts `bus_rd`.
- R6: `tick` and `done` are 1 in the last busy clock of every cycle and 0 in all other clocks.
- R7: A fetch addresses `pc_in`, and `pc_out` becomes `pc_in`+1 modulo 2^16.
- R8: A pop first increments SP. It addresses {0x01, `sp_in`+1 mod 256}, and `sp_out` becomes `sp_in`+1 mod 256.
- R9: A push addresses {0x01, `sp_in`}, and `sp_out` becomes `sp_in`-1 mod 256.
- R10: A direct-page read or write addresses `dp_sel`*256 + `req_offset`.
- R11: An absolute read or write addresses `req_addr`.
- R12: An operation that does not own PC or SP passes it through unchanged: `pc_out`=`pc_in` except for a fetch, and `sp_out`=`sp_in` except for a push or pop. Inputs that change after acceptance have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (see R2) |
| req_offset | input | 8 | Direct-page offset |
| req_addr | input | 16 | Absolute address |
| req_wdata | input | 8 | Write data |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| dp_sel | input | 1 | Direct-page select flag |
| busy | output | 1 | Cycle in flight |
| done | output | 1 | Last clock of the cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data to bus |
| bus_rdata | input | 8 | Read data from bus |
| rdata_out | output | 8 | Captured read byte |
| rdata_valid | output | 1 | Captured byte valid |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| tick | output | 1 | Timer tick strobe |

## Verification
The hardest situation to reach from the ports is a second request that arrives in the middle of a cycle already in flight, while the inputs it depends on are changing. The stimulus covers this by raising `req_valid` with a different operation partway through a cycle. At the same time it scrambles PC, SP, offset and address just after acceptance. The bench then confirms that the address, the strobe timing and the PC/SP results still match the request that was originally accepted. The wrap corners are driven directly: a fetch at PC 0xFFFF, a pop at SP 0xFF and a push at SP 0x00. Direct-page accesses are made with both flag values, and a large run of randomly mixed operations follows.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SP_W   = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE   = 3'd0,
        OP_FETCH  = 3'd1,
        OP_PUSH   = 3'd2,
        OP_POP    = 3'd3,
        OP_DP_RD  = 3'd4,
        OP_DP_WR  = 3'd5,
        OP_ABS_RD = 3'd6,
        OP_ABS_WR = 3'd7
    } bus_op_e;

    // Everything a cycle needs, fixed at acceptance
    typedef struct packed {
        bus_op_e            op;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [ADDR_W-1:0]  pc_next;
        logic [SP_W-1:0]    sp_next;
    } cycle_plan_t;

    function automatic logic op_reads(bus_op_e op);
        return (op == OP_FETCH) || (op == OP_POP) ||
               (op == OP_DP_RD) || (op == OP_ABS_RD);
    endfunction

    function automatic logic op_writes(bus_op_e op);
        return (op == OP_PUSH) || (op == OP_DP_WR) || (op == OP_ABS_WR);
    endfunction

endpackage

// File: rtl/busseq_addr_gen.sv
module busseq_addr_gen
    import busseq_pkg::*;
#(
    parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 8'h01
) (
    input  bus_op_e             op,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [SP_W-1:0]     sp,
    input  logic                dp_sel,
    input  logic [DATA_W-1:0]   offset,
    input  logic [ADDR_W-1:0]   abs_addr,
    input  logic [DATA_W-1:0]   wdata,
    output cycle_plan_t         plan
);
    localparam int DP_PAD = ADDR_W - DATA_W - 1;

    logic [SP_W-1:0]   sp_inc;
    logic [SP_W-1:0]   sp_dec;
    logic [ADDR_W-1:0] dp_addr;

    assign sp_inc  = sp + SP_W'(1);
    assign sp_dec  = sp - SP_W'(1);
    assign dp_addr = {{DP_PAD{1'b0}}, dp_sel, offset};

    always_comb begin
        plan.op      = op;
        plan.wdata   = wdata;
        plan.pc_next = pc;
        plan.sp_next = sp;
        plan.addr    = '0;
        unique case (op)
            OP_FETCH: begin
                plan.addr    = pc;
                plan.pc_next = pc + ADDR_W'(1);
            end
            OP_PUSH: begin
                plan.addr    = {STACK_PAGE, sp};
                plan.sp_next = sp_dec;
            end
            OP_POP: begin
                plan.addr    = {STACK_PAGE, sp_inc};
                plan.sp_next = sp_inc;
            end
            OP_DP_RD, OP_DP_WR:   plan.addr = dp_addr;
            OP_ABS_RD, OP_ABS_WR: plan.addr = abs_addr;
            default:              plan.addr = '0;
        endcase
    end

endmodule

// File: rtl/busseq_phase_timer.sv
module busseq_phase_timer #(
    parameter int CYC_LEN   = 24,
    parameter int SAMPLE_AT = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic sample_now,
    output logic post_sample,
    output logic last_now
);
    localparam int CW   = $clog2(CYC_LEN);
    localparam int LAST = CYC_LEN - 1;

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (cnt_q == CW'(LAST)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign busy        = busy_q;
    assign sample_now  = busy_q && (cnt_q == CW'(SAMPLE_AT - 1));
    assign post_sample = busy_q && (cnt_q == CW'(SAMPLE_AT));
    assign last_now    = busy_q && (cnt_q == CW'(LAST));

    // R2: a fresh cycle always starts from phase zero
    p_start_phase_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (cnt_q == '0));

    // R2: the last phase always closes the cycle
    p_last_closes_r2: assert property (@(posedge clk) disable iff (rst)
        last_now |=> !busy_q);

    // R2: the phase counter never runs past the cycle
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= CW'(LAST)));

endmodule

// File: rtl/cpu_bus_sequencer.sv
module cpu_bus_sequencer
    import busseq_pkg::*;
#(
    parameter int                     CYC_LEN    = 24,
    parameter int                     SAMPLE_AT  = 12,
    parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 8'h01
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [OP_W-1:0]     req_op,
    input  logic [DATA_W-1:0]   req_offset,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [ADDR_W-1:0]   pc_in,
    input  logic [SP_W-1:0]     sp_in,
    input  logic                dp_sel,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic [DATA_W-1:0]   rdata_out,
    output logic                rdata_valid,
    output logic [ADDR_W-1:0]   pc_out,
    output logic [SP_W-1:0]     sp_out,
    output logic                tick
);
    cycle_plan_t       plan_d;
    cycle_plan_t       plan_q;
    logic              accept;
    logic              sample_now;
    logic              post_sample;
    logic              last_now;
    logic [DATA_W-1:0] rdata_q;
    logic              cur_rd;
    logic              cur_wr;

    busseq_addr_gen #(.STACK_PAGE(STACK_PAGE)) u_agen (
        .op       (bus_op_e'(req_op)),
        .pc       (pc_in),
        .sp       (sp_in),
        .dp_sel   (dp_sel),
        .offset   (req_offset),
        .abs_addr (req_addr),
        .wdata    (req_wdata),
        .plan     (plan_d)
    );

    busseq_phase_timer #(.CYC_LEN(CYC_LEN), .SAMPLE_AT(SAMPLE_AT)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start       (req_valid),
        .busy        (busy),
        .sample_now  (sample_now),
        .post_sample (post_sample),
        .last_now    (last_now)
    );

    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q <= '0;
        end else if (accept) begin
            plan_q <= plan_d;
        end
    end

    assign cur_rd = op_reads(plan_q.op);
    assign cur_wr = op_writes(plan_q.op);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (sample_now && cur_rd) begin
            rdata_q <= bus_rdata;
        end
    end

    assign bus_addr    = plan_q.addr;
    assign bus_wdata   = plan_q.wdata;
    assign pc_out      = plan_q.pc_next;
    assign sp_out      = plan_q.sp_next;
    assign bus_rd      = sample_now && cur_rd;
    assign bus_wr      = last_now && cur_wr;
    assign rdata_out   = rdata_q;
    assign rdata_valid = post_sample && cur_rd;
    assign tick        = last_now;
    assign done        = last_now;

    // R3/R5: the two strobes never meet
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R2: the address is frozen for the whole cycle
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_addr));

    // R4: valid data always directly follows a read strobe
    p_valid_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> $past(bus_rd));

    // R6: each tick ends the cycle in flight
    p_tick_ends_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !busy);

    // R8/R9: stack traffic stays in the stack page
    p_stack_page_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && (plan_q.op == OP_POP || plan_q.op == OP_PUSH))
            |-> (bus_addr[ADDR_W-1:SP_W] == STACK_PAGE));

    // R6: strobes only inside a cycle
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr || tick) |-> busy);

endmodule

// File: tb/sim_cpu_bus_sequencer.sv
module sim_cpu_bus_sequencer;

    localparam int CYC = 24;
    localparam int SMP = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [7:0]  req_offset = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic        dp_sel = 1'b0;
    logic        busy, done, bus_rd, bus_wr, rdata_valid, tick;
    logic [15:0] bus_addr, pc_out;
    logic [7:0]  bus_wdata, bus_rdata, rdata_out, sp_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc_n  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_model(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    assign bus_rdata = mem_model(bus_addr);

    cpu_bus_sequencer u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_offset(req_offset), .req_addr(req_addr), .req_wdata(req_wdata),
        .pc_in(pc_in), .sp_in(sp_in), .dp_sel(dp_sel), .busy(busy),
        .done(done), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rdata_out(rdata_out),
        .rdata_valid(rdata_valid), .pc_out(pc_out), .sp_out(sp_out),
        .tick(tick)
    );

    function automatic bit is_rd(logic [2:0] op);
        return op == 3'd1 || op == 3'd3 || op == 3'd4 || op == 3'd6;
    endfunction
    function automatic bit is_wr(logic [2:0] op);
        return op == 3'd2 || op == 3'd5 || op == 3'd7;
    endfunction
    function automatic logic [15:0] exp_addr(logic [2:0] op, logic [15:0] pc,
            logic [7:0] sp, logic dp, logic [7:0] off, logic [15:0] ab);
        case (op)
            3'd1:       return pc;                          // R7
            3'd2:       return {8'h01, sp};                 // R9
            3'd3:       return {8'h01, 8'(sp + 8'd1)};      // R8
            3'd4, 3'd5: return 16'(dp) * 16'd256 + 16'(off); // R10
            3'd6, 3'd7: return ab;                          // R11
            default:    return 16'h0000;
        endcase
    endfunction
    function automatic logic [15:0] exp_pc(logic [2:0] op, logic [15:0] pc);
        return (op == 3'd1) ? 16'(pc + 16'd1) : pc;
    endfunction
    function automatic logic [7:0] exp_sp(logic [2:0] op, logic [7:0] sp);
        if (op == 3'd2) return 8'(sp - 8'd1);
        if (op == 3'd3) return 8'(sp + 8'd1);
        return sp;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic finish_up;
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_up();
        end
    end

    task automatic run_op(input logic [2:0] op, input logic [15:0] pc,
            input logic [7:0] sp, input logic dp, input logic [7:0] off,
            input logic [15:0] ab, input logic [7:0] wd, input bit poke);
        logic [15:0] ea;
        ea = exp_addr(op, pc, sp, dp, off, ab);
        @(negedge clk);
        chk("R2 idle before request", 32'(busy), 0);
        req_valid = 1'b1; req_op = op; pc_in = pc; sp_in = sp;
        dp_sel = dp; req_offset = off; req_addr = ab; req_wdata = wd;
        for (int k = 1; k <= CYC + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                // R12: inputs changing after acceptance must not matter
                req_valid = 1'b0;
                pc_in = pc_in ^ 16'h5A3C; sp_in = ~sp_in; dp_sel = ~dp_sel;
                req_offset = ~req_offset; req_addr = ~req_addr; req_wdata = ~req_wdata;
            end
            if (poke && k == 5) begin
                req_valid = 1'b1; req_op = op ^ 3'd5;   // R2: ignored while busy
            end
            if (poke && k == 6) req_valid = 1'b0;
            chk("R2 busy window", 32'(busy), 32'(k <= CYC));
            chk(is_wr(op) ? "R5 no read on write" : (op == 3'd0 ? "R3 idle no read" : "R4 read strobe"),
                32'(bus_rd), 32'(is_rd(op) && k == SMP));
            chk("R4 data valid", 32'(rdata_valid), 32'(is_rd(op) && k == SMP + 1));
            if (is_rd(op) && k == SMP + 1)
                chk("R4 captured data", 32'(rdata_out), 32'(mem_model(ea)));
            chk(op == 3'd0 ? "R3 idle no write" : "R5 write strobe",
                32'(bus_wr), 32'(is_wr(op) && k == CYC));
            if (is_wr(op) && k == CYC)
                chk("R5 write data", 32'(bus_wdata), 32'(wd));
            chk("R6 tick", 32'(tick), 32'(k == CYC));
            chk("R6 done", 32'(done), 32'(k == CYC));
            if (k == 1 || k == SMP || k == CYC)
                chk("R7 R8 R9 R10 R11 address", 32'(bus_addr), 32'(ea));
            if (k == CYC) begin
                chk("R7 R12 pc_out", 32'(pc_out), 32'(exp_pc(op, pc)));
                chk("R8 R9 R12 sp_out", 32'(sp_out), 32'(exp_sp(op, sp)));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rd", 32'(bus_rd), 0);
        chk("R1 wr", 32'(bus_wr), 0);
        chk("R1 valid", 32'(rdata_valid), 0);
        chk("R1 tick", 32'(tick), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 pc_out", 32'(pc_out), 0);
        chk("R1 sp_out", 32'(sp_out), 0);
        repeat (3) @(negedge clk);
        chk("R2 no request stays idle", 32'(busy), 0);

        // directed corners
        run_op(3'd1, 16'hFFFF, 8'h10, 1'b0, 8'h00, 16'h0000, 8'h00, 1'b0); // R7 wrap
        run_op(3'd3, 16'h1234, 8'hFF, 1'b0, 8'h00, 16'h0000, 8'h00, 1'b0); // R8 wrap
        run_op(3'd2, 16'h1234, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h3C, 1'b0); // R9 wrap
        run_op(3'd4, 16'h0100, 8'h40, 1'b1, 8'hFF, 16'h0000, 8'h00, 1'b0); // R10 page 1
        run_op(3'd5, 16'h0100, 8'h40, 1'b0, 8'h80, 16'h0000, 8'h99, 1'b0); // R10 page 0
        run_op(3'd6, 16'h0200, 8'h40, 1'b0, 8'h00, 16'hBEEF, 8'h00, 1'b0); // R11
        run_op(3'd7, 16'h0200, 8'h40, 1'b1, 8'h00, 16'hFFC3, 8'h7E, 1'b0); // R11
        run_op(3'd0, 16'h0300, 8'h55, 1'b1, 8'h12, 16'h4321, 8'h00, 1'b0); // R3 R12
        run_op(3'd1, 16'h0400, 8'h20, 1'b0, 8'h00, 16'h0000, 8'h00, 1'b1); // R2 poke
        run_op(3'd2, 16'h0400, 8'h20, 1'b0, 8'h00, 16'h0000, 8'hAB, 1'b1); // R2 poke

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            run_op(3'($urandom_range(0, 7)), 16'($urandom), 8'($urandom),
                   1'($urandom), 8'($urandom), 16'($urandom), 8'($urandom),
                   ($urandom_range(0, 3) == 0));
        end
        finish_up();
    end

endmodule